// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Controller

This block lets a half-duplex Ethernet station push back on its link partner when local receive buffering is congested. Backpressure is requested by a software activate bit or by a flow-control input from the FIFO layer. Either request counts only when transmit flow control is enabled and the port is in half-duplex mode. While backpressure is in effect, each new receive carrier event makes the block ask the transmitter to send a short fixed jam pattern. The partner sees a collision, backs off and retries later, which gives the local buffers time to drain.

The jam is a byte stream presented one byte per clock: a valid strobe, the jam byte and a last-byte marker. With the default parameters it is four bytes of alternating ones and zeros, 32 bits in all. Collision detection, backoff and the media-independent interface pins are handled elsewhere.

Top module: `bp_jam_ctrl`

## Requirements
- R1: `bp_active` is high exactly when `tx_flow_en` is 1, `full_duplex` is 0, and at least one of `sw_bp_act` or `fifo_flow_ctl` is 1.
- R2: When `full_duplex` is 1, `bp_active` is 0 and no jam starts, whatever the values of `sw_bp_act` and `fifo_flow_ctl`.
- R3: When `tx_flow_en` is 0, `bp_active` is 0 and no jam starts.
- R4: A jam starts when `rx_carrier` is sampled high after being low on the previous clock, `bp_active` is high in that same cycle, and no jam is running. `jam_valid` then rises on the next cycle and stays high for exactly JAM_BYTES (default 4) cycles. `jam_last` is high only in the final one of those cycles.
- R5: While `jam_valid` is 1, `jam_data` is the alternating pattern with its most significant bit set (8'hAA for 8-bit bytes). While `jam_valid` is 0, `jam_data` is 0.
- R6: At most one jam is issued per carrier event. While `rx_carrier` stays high, no further jam starts. If `bp_active` first goes high after the carrier has already risen, that carrier event produces no jam.
- R7: A jam that has started runs to its full length, even if `bp_active` falls or `rx_carrier` drops during it.
- R8: A carrier rising edge that arrives while a jam is running is ignored and does not lengthen or restart the jam.
- R9: During reset and on the first cycle after it, `jam_valid`, `jam_last` and `jam_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_flow_en | input | 1 | Transmit flow-control enable |
| sw_bp_act | input | 1 | Software backpressure request |
| fifo_flow_ctl | input | 1 | Flow-control request from the FIFO layer |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| rx_carrier | input | 1 | Receive carrier; a rising edge marks a new incoming frame |
| bp_active | output | 1 | Backpressure currently in effect |
| jam_valid | output | 1 | Jam byte presented to the transmitter this cycle |
| jam_data | output | BYTE_W | Jam byte |
| jam_last | output | 1 | Final byte of the jam |

## Verification
The assertions assume that `rx_carrier` is a synchronous level: every change is sampled at the clock, and a frame start is always a low-to-high transition. The carrier is never taken as a one-cycle pulse with edges between clocks. The stimulus drives every input only on the falling clock edge. The random phase holds the carrier at each level for several cycles and re-rolls the mode and request bits often, so that carrier edges fall before, during and after jams. Directed sequences cover the cases where the carrier is already high at reset release, the carrier rises in the middle of a jam, and backpressure drops partway through a jam.

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl #(
  parameter int JAM_BYTES = 4,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_flow_en,
  input  logic              sw_bp_act,
  input  logic              fifo_flow_ctl,
  input  logic              full_duplex,
  input  logic              rx_carrier,
  output logic              bp_active,
  output logic              jam_valid,
  output logic [BYTE_W-1:0] jam_data,
  output logic              jam_last
);

  localparam int CW = $clog2(JAM_BYTES + 1);

  function automatic logic [BYTE_W-1:0] alt_fill();
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = (i % 2) == 1;
    return r;
  endfunction

  localparam logic [BYTE_W-1:0] JAM_BYTE = alt_fill();

  logic          carrier_q;
  logic [CW-1:0] left;
  logic          jam_start;

  assign bp_active = tx_flow_en & ~full_duplex & (sw_bp_act | fifo_flow_ctl);
  assign jam_start = (left == '0) & rx_carrier & ~carrier_q & bp_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrier_q <= 1'b0;
      left      <= '0;
    end else begin
      carrier_q <= rx_carrier;
      if (left != '0)
        left <= left - 1'b1;
      else if (jam_start)
        left <= CW'(JAM_BYTES);
    end
  end

  assign jam_valid = (left != '0);
  assign jam_last  = (left == CW'(1));
  assign jam_data  = jam_valid ? JAM_BYTE : '0;

  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_valid) |-> $past(rx_carrier) && $past(bp_active));

  p_start_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_valid && rx_carrier && !carrier_q && bp_active) |=> jam_valid);

  p_end_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jam_last |=> !jam_valid);

  p_run_to_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_valid && !jam_last) |=> jam_valid);

  p_held_carrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_carrier && carrier_q && !jam_valid) |=> !jam_valid);

  p_no_bp_no_jam_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_valid && (full_duplex || !tx_flow_en)) |=> !jam_valid);

  p_no_jam_after_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !jam_valid && !jam_last);

endmodule

// File: tb/bp_jam_ctrl_bench.sv
module bp_jam_ctrl_bench;
  localparam int JB = 4;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n, tx_flow_en, sw_bp_act, fifo_flow_ctl, full_duplex, rx_carrier;
  logic bp_active, jam_valid, jam_last;
  logic [BW-1:0] jam_data;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_left = 0;
  logic m_carr_q = 1'b0;

  always #5 clk = ~clk;

  bp_jam_ctrl #(.JAM_BYTES(JB), .BYTE_W(BW)) u_bp_jam_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_flow_en(tx_flow_en), .sw_bp_act(sw_bp_act),
    .fifo_flow_ctl(fifo_flow_ctl), .full_duplex(full_duplex), .rx_carrier(rx_carrier),
    .bp_active(bp_active), .jam_valid(jam_valid), .jam_data(jam_data), .jam_last(jam_last));

  function automatic logic exp_bp(logic en, logic sw, logic ff, logic fd);
    return en && !fd && (sw || ff);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic en, logic sw, logic ff, logic fd, logic car);
    tx_flow_en = en; sw_bp_act = sw; fifo_flow_ctl = ff; full_duplex = fd; rx_carrier = car;
  endtask

  task automatic step(string req);
    logic b;
    #1;
    b = exp_bp(tx_flow_en, sw_bp_act, fifo_flow_ctl, full_duplex);
    chk(req, "bp_active", {31'd0, bp_active}, {31'd0, b});
    @(posedge clk);
    if (m_left != 0) m_left--;
    else if (rx_carrier && !m_carr_q && b) m_left = JB;
    m_carr_q = rx_carrier;
    #1;
    chk(req, "jam_valid", {31'd0, jam_valid}, {31'd0, m_left != 0});
    chk(req, "jam_last", {31'd0, jam_last}, {31'd0, m_left == 1});
    chk("R5", "jam_data", {24'd0, jam_data}, (m_left != 0) ? 32'hAA : 32'h0);
    @(negedge clk);
  endtask

  task automatic do_reset(logic car);
    rst_n = 1'b0;
    drive(1, 1, 0, 0, car);
    @(negedge clk); @(negedge clk);
    chk("R9", "jam_valid in reset", {31'd0, jam_valid}, 32'd0);
    chk("R9", "jam_data in reset", {24'd0, jam_data}, 32'd0);
    rst_n = 1'b1;
    m_left = 0; m_carr_q = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    do_reset(0);
    step("R9");

    // R1 gating truth table
    for (int i = 0; i < 16; i++) begin
      drive(i[0], i[1], i[2], i[3], 0);
      step("R1");
    end

    // R2 full duplex blocks jam
    drive(1, 1, 1, 1, 0); step("R2");
    drive(1, 1, 1, 1, 1); step("R2"); step("R2");
    // R3 flow disabled blocks jam
    drive(0, 1, 1, 0, 0); step("R3");
    drive(0, 1, 1, 0, 1); step("R3"); step("R3");

    // R4 normal jam from software bit
    drive(1, 1, 0, 0, 0); step("R4");
    drive(1, 1, 0, 0, 1);
    for (int k = 0; k < JB + 3; k++) step("R4");
    // R6 carrier held high: no second jam
    for (int k = 0; k < 4; k++) step("R6");
    drive(1, 0, 0, 0, 0); step("R6");
    drive(1, 0, 0, 0, 1); step("R6");
    drive(1, 0, 1, 0, 1); for (int k = 0; k < 3; k++) step("R6");

    // R7 bp drops during jam
    drive(1, 0, 1, 0, 0); step("R7");
    drive(1, 0, 1, 0, 1); step("R7");
    drive(1, 0, 0, 1, 0); for (int k = 0; k < JB + 2; k++) step("R7");

    // R8 carrier re-rises mid-jam
    drive(1, 0, 1, 0, 0); step("R8");
    drive(1, 0, 1, 0, 1); step("R8");
    drive(1, 0, 1, 0, 0); step("R8");
    drive(1, 0, 1, 0, 1); for (int k = 0; k < JB + 2; k++) step("R8");

    // R9 carrier high across reset release counts as a new edge
    do_reset(1);
    drive(1, 1, 0, 0, 1);
    for (int k = 0; k < JB + 2; k++) step("R9");

    // constrained random, R4 and R1 checked by model
    for (int n = 0; n < 400; n++) begin
      logic en, sw, ff, fd, car;
      int hold;
      en = ($urandom % 4) != 0;
      sw = $urandom % 2;
      ff = $urandom % 2;
      fd = ($urandom % 5) == 0;
      car = $urandom % 2;
      hold = 1 + ($urandom % 6);
      drive(en, sw, ff, fd, car);
      for (int k = 0; k < hold; k++) step("R4");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule